// File: doc/BRIEF.md
# Microprogram Address Sequencer with Opcode Dispatch

This block produces the address of the next microinstruction for a microprogrammed multicycle processor controller. It holds a small micro-address register. Each cycle, a two-bit sequencing field taken from the current microinstruction chooses how the register moves: back to the fetch entry, through a fixed table that turns the instruction opcode into the first execute step of that instruction, one step forward, or no move at all.

Memory latency is handled inside the sequencer. While the instruction memory reports that it is waiting and the register sits at the fetch entry, the address does not move. While the data memory reports that it is waiting and the register sits at one of the data-access steps (load read or store write), the address also does not move. In both cases the sequencing field is overruled. The control store that the address indexes and the datapath it drives lie outside this block.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets `uaddr` to 0000 at the next rising clock edge, whatever the other inputs are.
- R2: With `seq_ctl` = 00 and no wait hold, `uaddr` is 0000 after the next edge.
- R3: With `seq_ctl` = 01 and no wait hold, `uaddr` after the next edge is taken from the opcode table: 000000 gives 0100, 000100 gives 0011, 001101 gives 0110, 100011 gives 1000 and 101011 gives 1011.
- R4: With `seq_ctl` = 01 and an opcode not listed in R3, `uaddr` is 0000 after the next edge.
- R5: With `seq_ctl` = 10 and no wait hold, `uaddr` advances by one at the next edge, and 1111 advances to 0000.
- R6: With `seq_ctl` = 11, `uaddr` keeps its value at the next edge.
- R7: While `uaddr` is 0000 and `imem_wait` is high, `uaddr` keeps its value whatever `seq_ctl` is; at any other address `imem_wait` has no effect.
- R8: While `uaddr` is 1001 (load data access) or 1100 (store data access) and `dmem_wait` is high, `uaddr` keeps its value whatever `seq_ctl` is; at any other address `dmem_wait` has no effect.
- R9: `opcode` has no effect unless `seq_ctl` is 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| seq_ctl | input | 2 | Sequencing field: 00 restart, 01 dispatch, 10 step, 11 hold |
| opcode | input | 6 | Opcode of the instruction held in the instruction register |
| imem_wait | input | 1 | Instruction memory has not yet returned data |
| dmem_wait | input | 1 | Data memory has not yet completed the access |
| uaddr | output | 4 | Current micro-address |

## Verification
The micro-address register is the only state, and it is also the output, so any wrong value is visible at `uaddr` in the same cycle it is loaded; there is nothing hidden that could stay latent. A wrong table entry shows one cycle after a dispatch with that opcode, so every listed opcode and one unlisted opcode are dispatched. A wait hold that fires at the wrong address or fails to fire at the right one shows one cycle later as a stuck or moved address, so each wait flag is raised both at its own steps and at unrelated steps.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      SEQ_RESTART  = 2'b00,
      SEQ_DISPATCH = 2'b01,
      SEQ_STEP     = 2'b10,
      SEQ_HOLD     = 2'b11
   } seq_ctl_e;

   localparam int unsigned TABLE_OP_W = 6;
   localparam int unsigned TABLE_UA_W = 4;

   // Opcode to first execute step; hit is low for an unlisted opcode.
   function automatic logic [TABLE_UA_W:0] dispatch_lookup(input logic [TABLE_OP_W-1:0] op);
      logic [TABLE_UA_W:0] res;
      case (op)
         6'b000000: res = {1'b1, 4'b0100};
         6'b000100: res = {1'b1, 4'b0011};
         6'b001101: res = {1'b1, 4'b0110};
         6'b100011: res = {1'b1, 4'b1000};
         6'b101011: res = {1'b1, 4'b1011};
         default:   res = {1'b0, 4'b0000};
      endcase
      return res;
   endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
   parameter int unsigned OP_W       = 6,
   parameter int unsigned UA_W       = 4,
   parameter int unsigned FETCH_ADDR = 0
) (
   input  logic [OP_W-1:0] op_in,
   output logic [UA_W-1:0] target
);
   import useq_pkg::*;

   logic [TABLE_UA_W:0] entry;

   always_comb begin
      entry = dispatch_lookup(op_in);
   end

   generate
      if (UA_W == TABLE_UA_W) begin : g_same_w
         assign target = entry[TABLE_UA_W] ? entry[TABLE_UA_W-1:0] : UA_W'(FETCH_ADDR);
      end else begin : g_wide
         assign target = entry[TABLE_UA_W]
                         ? {{(UA_W-TABLE_UA_W){1'b0}}, entry[TABLE_UA_W-1:0]}
                         : UA_W'(FETCH_ADDR);
      end
   endgenerate
endmodule

// File: rtl/useq_wait_hold.sv
module useq_wait_hold #(
   parameter int unsigned                   UA_W        = 4,
   parameter int unsigned                   FETCH_ADDR  = 0,
   parameter int unsigned                   N_DMEM      = 2,
   parameter logic [N_DMEM*UA_W-1:0]        DMEM_STATES = 8'hC9
) (
   input  logic [UA_W-1:0] cur,
   input  logic            imem_wait,
   input  logic            dmem_wait,
   output logic            hold
);
   logic [N_DMEM-1:0] dmem_hit;

   genvar gi;
   generate
      for (gi = 0; gi < N_DMEM; gi++) begin : g_dmem
         assign dmem_hit[gi] = (cur == DMEM_STATES[gi*UA_W +: UA_W]);
      end
   endgenerate

   assign hold = ((cur == UA_W'(FETCH_ADDR)) && imem_wait) || ((|dmem_hit) && dmem_wait);
endmodule

// File: rtl/useq_next.sv
module useq_next #(
   parameter int unsigned UA_W       = 4,
   parameter int unsigned FETCH_ADDR = 0
) (
   input  useq_pkg::seq_ctl_e ctl,
   input  logic [UA_W-1:0]    cur,
   input  logic [UA_W-1:0]    disp_target,
   input  logic               hold,
   output logic [UA_W-1:0]    nxt
);
   import useq_pkg::*;

   always_comb begin
      nxt = cur;
      if (!hold) begin
         case (ctl)
            SEQ_RESTART:  nxt = UA_W'(FETCH_ADDR);
            SEQ_DISPATCH: nxt = disp_target;
            SEQ_STEP:     nxt = cur + UA_W'(1);
            default:      nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
   parameter int unsigned            UA_W        = 4,
   parameter int unsigned            OP_W        = 6,
   parameter int unsigned            FETCH_ADDR  = 0,
   parameter int unsigned            N_DMEM      = 2,
   parameter logic [N_DMEM*UA_W-1:0] DMEM_STATES = 8'hC9
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      seq_ctl,
   input  logic [OP_W-1:0] opcode,
   input  logic            imem_wait,
   input  logic            dmem_wait,
   output logic [UA_W-1:0] uaddr
);
   import useq_pkg::*;

   localparam int unsigned UA_DEPTH = 1 << UA_W;

   generate
      if (UA_W < TABLE_UA_W) begin : g_bad_ua_w
         $error("UA_W is narrower than the dispatch table entries");
      end
      if (OP_W != TABLE_OP_W) begin : g_bad_op_w
         $error("OP_W must match the dispatch table opcode width");
      end
      if (FETCH_ADDR >= UA_DEPTH) begin : g_bad_fetch
         $error("FETCH_ADDR lies outside the micro-address space");
      end
      if (N_DMEM == 0) begin : g_bad_ndmem
         $error("N_DMEM must be at least one");
      end
   endgenerate

   logic [UA_W-1:0] upc_q;
   logic [UA_W-1:0] upc_d;
   logic [UA_W-1:0] disp_target;
   logic            wait_hold;
   seq_ctl_e        ctl;

   assign ctl = seq_ctl_e'(seq_ctl);

   useq_dispatch #(
      .OP_W       (OP_W),
      .UA_W       (UA_W),
      .FETCH_ADDR (FETCH_ADDR)
   ) i_dispatch (
      .op_in  (opcode),
      .target (disp_target)
   );

   useq_wait_hold #(
      .UA_W        (UA_W),
      .FETCH_ADDR  (FETCH_ADDR),
      .N_DMEM      (N_DMEM),
      .DMEM_STATES (DMEM_STATES)
   ) i_wait_hold (
      .cur       (upc_q),
      .imem_wait (imem_wait),
      .dmem_wait (dmem_wait),
      .hold      (wait_hold)
   );

   useq_next #(
      .UA_W       (UA_W),
      .FETCH_ADDR (FETCH_ADDR)
   ) i_next (
      .ctl         (ctl),
      .cur         (upc_q),
      .disp_target (disp_target),
      .hold        (wait_hold),
      .nxt         (upc_d)
   );

   always_ff @(posedge clk) begin
      if (rst) upc_q <= UA_W'(FETCH_ADDR);
      else     upc_q <= upc_d;
   end

   assign uaddr = upc_q;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
   parameter int unsigned            UA_W        = 4,
   parameter int unsigned            OP_W        = 6,
   parameter int unsigned            FETCH_ADDR  = 0,
   parameter int unsigned            N_DMEM      = 2,
   parameter logic [N_DMEM*UA_W-1:0] DMEM_STATES = 8'hC9
) (
   input logic            clk,
   input logic            rst,
   input logic [1:0]      seq_ctl,
   input logic [OP_W-1:0] opcode,
   input logic            imem_wait,
   input logic            dmem_wait,
   input logic [UA_W-1:0] uaddr
);
   import useq_pkg::*;

   logic in_dmem;
   logic held;
   logic [TABLE_UA_W:0] ref_entry;
   logic [UA_W-1:0]     ref_target;

   always_comb begin
      in_dmem = 1'b0;
      for (int k = 0; k < int'(N_DMEM); k++) begin
         if (uaddr == DMEM_STATES[k*UA_W +: UA_W]) in_dmem = 1'b1;
      end
      held       = ((uaddr == UA_W'(FETCH_ADDR)) && imem_wait) || (in_dmem && dmem_wait);
      ref_entry  = dispatch_lookup(TABLE_OP_W'(opcode));
      ref_target = ref_entry[TABLE_UA_W] ? UA_W'(ref_entry[TABLE_UA_W-1:0]) : UA_W'(FETCH_ADDR);
   end

   // R1
   reset_to_fetch_chk: assert property (@(posedge clk) rst |=> uaddr == UA_W'(FETCH_ADDR));

   // R2
   restart_code_chk: assert property (@(posedge clk) disable iff (rst)
      (!held && seq_ctl == 2'b00) |=> uaddr == UA_W'(FETCH_ADDR));

   // R3
   dispatch_code_chk: assert property (@(posedge clk) disable iff (rst)
      (!held && seq_ctl == 2'b01) |=> uaddr == $past(ref_target));

   // R5
   step_code_chk: assert property (@(posedge clk) disable iff (rst)
      (!held && seq_ctl == 2'b10) |=> uaddr == $past(uaddr) + UA_W'(1));

   // R6
   hold_code_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_ctl == 2'b11) |=> $stable(uaddr));

   // R7
   imem_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (uaddr == UA_W'(FETCH_ADDR) && imem_wait) |=> $stable(uaddr));

   // R8
   dmem_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (in_dmem && dmem_wait) |=> $stable(uaddr));
endmodule

bind useq_sequencer useq_sequencer_chk #(
   .UA_W        (UA_W),
   .OP_W        (OP_W),
   .FETCH_ADDR  (FETCH_ADDR),
   .N_DMEM      (N_DMEM),
   .DMEM_STATES (DMEM_STATES)
) i_useq_sequencer_chk (
   .clk       (clk),
   .rst       (rst),
   .seq_ctl   (seq_ctl),
   .opcode    (opcode),
   .imem_wait (imem_wait),
   .dmem_wait (dmem_wait),
   .uaddr     (uaddr)
);

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] seq_ctl = 2'b11;
   logic [5:0] opcode = 6'd0;
   logic       imem_wait = 1'b0;
   logic       dmem_wait = 1'b0;
   logic [3:0] uaddr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   useq_sequencer i_useq_sequencer (
      .clk       (clk),
      .rst       (rst),
      .seq_ctl   (seq_ctl),
      .opcode    (opcode),
      .imem_wait (imem_wait),
      .dmem_wait (dmem_wait),
      .uaddr     (uaddr)
   );

   // {ctl[13:12], opcode[11:6], imem_wait[5], dmem_wait[4], expected[3:0]}
   localparam int NVEC = 19;
   localparam logic [13:0] VEC [NVEC] = '{
      {2'b10, 6'b000000, 1'b1, 1'b0, 4'd0},   // R7 fetch waits
      {2'b10, 6'b000000, 1'b0, 1'b0, 4'd1},   // R5
      {2'b01, 6'b100011, 1'b0, 1'b0, 4'd8},   // R3 load
      {2'b10, 6'b100011, 1'b0, 1'b0, 4'd9},   // R5
      {2'b10, 6'b100011, 1'b0, 1'b1, 4'd9},   // R8 load access waits
      {2'b10, 6'b100011, 1'b1, 1'b0, 4'd10},  // R7 imem_wait ignored off fetch
      {2'b00, 6'b100011, 1'b0, 1'b0, 4'd0},   // R2
      {2'b10, 6'b101011, 1'b0, 1'b0, 4'd1},   // R5
      {2'b01, 6'b101011, 1'b0, 1'b0, 4'd11},  // R3 store
      {2'b10, 6'b101011, 1'b0, 1'b0, 4'd12},  // R5
      {2'b00, 6'b101011, 1'b0, 1'b1, 4'd12},  // R8 store access waits over restart
      {2'b11, 6'b101011, 1'b0, 1'b0, 4'd12},  // R6
      {2'b10, 6'b000000, 1'b0, 1'b0, 4'd13},  // R5
      {2'b01, 6'b000000, 1'b0, 1'b0, 4'd4},   // R3 register type
      {2'b01, 6'b000100, 1'b0, 1'b0, 4'd3},   // R3 branch
      {2'b01, 6'b001101, 1'b0, 1'b0, 4'd6},   // R3 or-immediate
      {2'b01, 6'b111111, 1'b0, 1'b0, 4'd0},   // R4 unlisted opcode
      {2'b10, 6'b000000, 1'b0, 1'b0, 4'd1},   // R9 opcode ignored on step
      {2'b00, 6'b100011, 1'b0, 1'b1, 4'd0}    // R8 dmem_wait ignored, R9
   };

   task automatic check(input logic [3:0] exp, input string req);
      checks++;
      if (uaddr !== exp) begin
         errors++;
         $display("FAIL %s uaddr=%b expected=%b", req, uaddr, exp);
      end
   endtask

   task automatic cycle(input logic r, input logic [1:0] c, input logic [5:0] op,
                        input logic iw, input logic dw);
      @(negedge clk);
      rst = r; seq_ctl = c; opcode = op; imem_wait = iw; dmem_wait = dw;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cycle(1'b1, 2'b11, 6'd0, 1'b0, 1'b0);
      check(4'd0, "R1");

      for (int i = 0; i < NVEC; i++) begin
         cycle(1'b0, VEC[i][13:12], VEC[i][11:6], VEC[i][5], VEC[i][4]);
         check(VEC[i][3:0], $sformatf("R2..R9 vector %0d", i));
      end

      // R5 wrap from 1111 to 0000
      cycle(1'b0, 2'b01, 6'b101011, 1'b0, 1'b0);   // 11
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b1);        // 12, dmem_wait ignored at 11
      check(4'd12, "R8");
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b0);        // 13
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b0);        // 14
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b0);        // 15
      check(4'd15, "R5");
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b0);
      check(4'd0, "R5 wrap");

      // R9 opcode ignored under hold code
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b0);        // 1
      cycle(1'b0, 2'b11, 6'b100011, 1'b0, 1'b0);
      check(4'd1, "R9");

      // R7 fetch wait overrides dispatch, then releases
      cycle(1'b0, 2'b00, 6'd0, 1'b0, 1'b0);        // 0
      cycle(1'b0, 2'b01, 6'b000100, 1'b1, 1'b0);
      check(4'd0, "R7");
      cycle(1'b0, 2'b01, 6'b000100, 1'b0, 1'b0);
      check(4'd3, "R7 release");

      // R1 reset mid-run overrides hold code and waits
      cycle(1'b0, 2'b10, 6'd0, 1'b0, 1'b0);        // 4
      cycle(1'b1, 2'b11, 6'd0, 1'b1, 1'b1);
      check(4'd0, "R1 mid-run");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule